// File: doc/BRIEF.md
# Gap-Modulated Frame Generator

This block sends a run of fixed-length frames as a stream of line characters, one character per clock. Each frame is a start character, a body of payload characters and a terminate character. The body characters carry a running byte index. The block does not build frame headers, checksums or line coding. Between two frames it emits idle characters. The number of idles is an exact count, so the spacing between frames is identical from one frame to the next.

Software sets up the run before it starts. It gives the number of frames, the body length in characters, a base gap in idle characters, a gap offset and a covert-mode enable. A start pulse then launches the run. In covert mode each gap carries one hidden bit, which the block takes from a valid/ready bit input. A '1' widens that gap by the offset and a '0' narrows it by the same amount. The run ends when the programmed frame count has been sent, or at the end of the frame and gap that are in progress when a stop pulse arrives. Typical measurement values are a body of 1518 characters, a base gap of 3562 idles and an offset of 128 idles.

Top module: `gap_mod_frame_gen`

## Requirements
- R1: After reset, `ch_kind` shows idle (code 0), and `busy`, `done` and `bit_ready` are all low.
- R2: Each frame is exactly one start character (code 1), then L body characters (code 2), then one terminate character (code 3). The i-th body character (counting from 0) carries `ch_data` = i mod 256.
- R3: With covert mode off, exactly G idle characters (code 0) separate a terminate character from the next start character. The final gap is counted up to the rise of `done`. G is the latched base gap.
- R4: A latched base gap below 12 is raised to 12 before it is used.
- R5: In covert mode, a gap whose bit is taken with value 1 lasts the clamped base plus the offset. The result saturates at the largest value of the gap width.
- R6: In covert mode, a gap whose bit is taken with value 0 lasts the clamped base minus the offset. It never goes below 12.
- R7: `bit_ready` is high only during terminate characters, and only when covert mode is on. A bit is taken when `bit_valid` is high in that cycle. If no bit is offered there, the gap is the clamped base.
- R8: A run sends exactly the latched frame count and then emits only idles. `done` rises in the first cycle after the last gap, together with `busy` falling. A start with a frame count of 0 sends nothing and raises `done` in the next cycle.
- R9: A stop pulse during a run lets the current frame and its gap finish, then ends the run with `done` high. A stop pulse while idle has no effect on the next run.
- R10: All configuration inputs are latched on an accepted start. A start pulse or a configuration change during a run has no effect on that run.
- R11: A latched body length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_start | input | 1 | Start pulse; accepted only while not busy |
| run_stop | input | 1 | Stop pulse; ends the run after the current frame and gap |
| cfg_frame_count | input | CNT_W | Frames per run |
| cfg_frame_len | input | CNT_W | Body characters per frame |
| cfg_base_gap | input | GAP_W | Base gap in idle characters |
| cfg_gap_offset | input | GAP_W | Covert gap offset in idle characters |
| cfg_covert | input | 1 | Covert modulation enable |
| bit_valid | input | 1 | A covert bit is offered |
| bit_data | input | 1 | Offered covert bit value |
| bit_ready | output | 1 | Covert bit is taken this cycle when valid |
| ch_kind | output | 2 | Character kind: 0 idle, 1 start, 2 body, 3 terminate |
| ch_data | output | 8 | Body byte index (0 for other kinds) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has completed |

## Verification
Suppose a start pulse is sampled at clock edge e. The start character then appears in the cycle after e. Body character i appears i+1 cycles later, and the terminate character follows the last body character directly. `done` and the drop of `busy` appear in the cycle right after the last gap idle. The covert bit is sampled during the terminate cycle itself. Inputs change just after a rising edge, and the bench's stream monitor samples every output at the falling edge. Gaps are measured by counting idle characters between a terminate and the next start (or the rise of `done`). Because of this, no check depends on guessing an absolute cycle number.

// File: rtl/gfg_pkg.sv
package gfg_pkg;
  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_START = 2'd1,
    CH_DATA  = 2'd2,
    CH_TERM  = 2'd3
  } ch_kind_e;

  typedef enum logic [2:0] {
    SQ_OFF,
    SQ_SOF,
    SQ_BODY,
    SQ_EOF,
    SQ_GAP
  } seq_state_e;
endpackage

// File: rtl/gfg_cfg_hold.sv
module gfg_cfg_hold #(
  parameter int CNT_W = 16,
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] count_in,
  input  logic [CNT_W-1:0] len_in,
  input  logic [GAP_W-1:0] base_in,
  input  logic [GAP_W-1:0] off_in,
  input  logic             covert_in,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] len_q,
  output logic [GAP_W-1:0] base_q,
  output logic [GAP_W-1:0] off_q,
  output logic             covert_q
);
  localparam logic [CNT_W-1:0] LEN_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      len_q    <= LEN_ONE;
      base_q   <= '0;
      off_q    <= '0;
      covert_q <= 1'b0;
    end else if (load) begin
      count_q  <= count_in;
      len_q    <= (len_in == '0) ? LEN_ONE : len_in;
      base_q   <= base_in;
      off_q    <= off_in;
      covert_q <= covert_in;
    end
  end

  // R11: the held body length is never zero
  a_r11_len_nonzero: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> (len_q != '0));
endmodule

// File: rtl/gfg_gap_sel.sv
module gfg_gap_sel #(
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 12
) (
  input  logic [GAP_W-1:0] base,
  input  logic [GAP_W-1:0] offset,
  input  logic             covert,
  input  logic             bit_ok,
  input  logic             bit_val,
  output logic [GAP_W-1:0] gap_len
);
  localparam int XW = GAP_W + 1;
  localparam logic [XW-1:0] LIM = XW'(MIN_GAP);

  logic [XW-1:0] eb, up, floor_chk;
  logic [GAP_W-1:0] gap_up, gap_dn;

  always_comb begin
    eb        = ({1'b0, base} < LIM) ? LIM : {1'b0, base};
    up        = eb + {1'b0, offset};
    floor_chk = {1'b0, offset} + LIM;
    gap_up    = up[GAP_W] ? '1 : up[GAP_W-1:0];
    gap_dn    = (floor_chk > eb) ? LIM[GAP_W-1:0] : (eb[GAP_W-1:0] - offset);
    if (!covert || !bit_ok) gap_len = eb[GAP_W-1:0];
    else if (bit_val)       gap_len = gap_up;
    else                    gap_len = gap_dn;
  end
endmodule

// File: rtl/gfg_seq.sv
module gfg_seq
  import gfg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic             count_in_zero,
  input  logic [CNT_W-1:0] count_q,
  input  logic [CNT_W-1:0] len_q,
  input  logic [GAP_W-1:0] gap_len,
  input  logic             covert_q,
  output logic             load,
  output logic [1:0]       ch_kind,
  output logic [7:0]       ch_data,
  output logic             bit_ready,
  output logic             busy,
  output logic             done
);
  seq_state_e       state;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] sent;
  logic [GAP_W-1:0] gap_cnt;
  logic             stop_pend;
  logic             stop_now;

  assign load      = run_start && (state == SQ_OFF);
  assign stop_now  = stop_pend || run_stop;
  assign busy      = (state != SQ_OFF);
  assign bit_ready = (state == SQ_EOF) && covert_q;

  always_comb begin
    unique case (state)
      SQ_SOF:  ch_kind = CH_START;
      SQ_BODY: ch_kind = CH_DATA;
      SQ_EOF:  ch_kind = CH_TERM;
      default: ch_kind = CH_IDLE;
    endcase
    ch_data = (state == SQ_BODY) ? idx[7:0] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_OFF;
      idx       <= '0;
      sent      <= '0;
      gap_cnt   <= '0;
      stop_pend <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (run_stop && busy) stop_pend <= 1'b1;
      unique case (state)
        SQ_OFF: begin
          if (run_start) begin
            stop_pend <= 1'b0;
            sent      <= '0;
            if (count_in_zero) done <= 1'b1;
            else begin
              done  <= 1'b0;
              state <= SQ_SOF;
            end
          end
        end
        SQ_SOF: begin
          idx   <= '0;
          state <= SQ_BODY;
        end
        SQ_BODY: begin
          idx <= idx + 1'b1;
          if (idx == len_q - 1'b1) state <= SQ_EOF;
        end
        SQ_EOF: begin
          gap_cnt <= gap_len - 1'b1;
          sent    <= sent + 1'b1;
          state   <= SQ_GAP;
        end
        SQ_GAP: begin
          if (gap_cnt == '0) begin
            if (stop_now || sent == count_q) begin
              state     <= SQ_OFF;
              done      <= 1'b1;
              stop_pend <= 1'b0;
            end else begin
              state <= SQ_SOF;
            end
          end else begin
            gap_cnt <= gap_cnt - 1'b1;
          end
        end
        default: state <= SQ_OFF;
      endcase
    end
  end

  // R2: a start character is always followed by body characters
  a_r2_sof_to_body: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_SOF) |=> (state == SQ_BODY));
  // R4: the gap chosen at the terminate character is never below the floor
  a_r4_gap_floor: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_EOF) |-> (gap_len >= GAP_W'(MIN_GAP)));
  // R7: the bit handshake is offered only on terminate characters
  a_r7_ready_on_term: assert property (@(posedge clk) disable iff (rst)
    bit_ready |-> (ch_kind == CH_TERM));
  // R8: done and busy never overlap
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9: a frame body is never cut short by a stop
  a_r9_body_whole: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_BODY) |=> (state == SQ_BODY || state == SQ_EOF));
endmodule

// File: rtl/gap_mod_frame_gen.sv
module gap_mod_frame_gen #(
  parameter int CNT_W   = 16,
  parameter int GAP_W   = 16,
  parameter int MIN_GAP = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_start,
  input  logic             run_stop,
  input  logic [CNT_W-1:0] cfg_frame_count,
  input  logic [CNT_W-1:0] cfg_frame_len,
  input  logic [GAP_W-1:0] cfg_base_gap,
  input  logic [GAP_W-1:0] cfg_gap_offset,
  input  logic             cfg_covert,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic [1:0]       ch_kind,
  output logic [7:0]       ch_data,
  output logic             busy,
  output logic             done
);
  logic             load;
  logic [CNT_W-1:0] count_q, len_q;
  logic [GAP_W-1:0] base_q, off_q, gap_len;
  logic             covert_q;

  gfg_cfg_hold #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_hold (
    .clk(clk), .rst(rst), .load(load),
    .count_in(cfg_frame_count), .len_in(cfg_frame_len),
    .base_in(cfg_base_gap), .off_in(cfg_gap_offset), .covert_in(cfg_covert),
    .count_q(count_q), .len_q(len_q), .base_q(base_q), .off_q(off_q),
    .covert_q(covert_q)
  );

  gfg_gap_sel #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
    .base(base_q), .offset(off_q), .covert(covert_q),
    .bit_ok(bit_valid), .bit_val(bit_data), .gap_len(gap_len)
  );

  gfg_seq #(.CNT_W(CNT_W), .GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_seq (
    .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
    .count_in_zero(cfg_frame_count == '0), .count_q(count_q), .len_q(len_q),
    .gap_len(gap_len), .covert_q(covert_q), .load(load),
    .ch_kind(ch_kind), .ch_data(ch_data), .bit_ready(bit_ready),
    .busy(busy), .done(done)
  );
endmodule

// File: tb/sim_gap_mod_frame_gen.sv
module sim_gap_mod_frame_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic run_start = 1'b0, run_stop = 1'b0;
  logic [15:0] cfg_frame_count = '0, cfg_frame_len = '0;
  logic [15:0] cfg_base_gap = '0, cfg_gap_offset = '0;
  logic cfg_covert = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, busy, done;
  logic [1:0] ch_kind;
  logic [7:0] ch_data;

  int checks = 0, failures = 0;
  int r_base, r_off, r_len, r_count;
  bit r_cov;
  bit mon_en = 0, in_gap = 0;
  int mon_frames, gap_len, idx, gi, ti;
  int exp_q[64];
  string tag_q[64];

  always #(CLK_PERIOD/2) clk = ~clk;

  gap_mod_frame_gen u0 (
    .clk(clk), .rst(rst), .run_start(run_start), .run_stop(run_stop),
    .cfg_frame_count(cfg_frame_count), .cfg_frame_len(cfg_frame_len),
    .cfg_base_gap(cfg_base_gap), .cfg_gap_offset(cfg_gap_offset),
    .cfg_covert(cfg_covert), .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .ch_kind(ch_kind), .ch_data(ch_data),
    .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(int b, int o, bit cov, bit v, bit d);
    int eb = (b < 12) ? 12 : b;
    if (!cov || !v) return eb;
    if (d) return (eb + o > 65535) ? 65535 : eb + o;
    return (eb - o < 12) ? 12 : eb - o;
  endfunction

  function automatic string gap_tag(int b, bit cov, bit v, bit d);
    if (cov && !v) return "R7";
    if (cov) return d ? "R5" : "R6";
    return (b < 12) ? "R4" : "R3";
  endfunction

  // stream monitor, samples at the falling edge
  always @(negedge clk) begin
    if (mon_en) begin
      case (ch_kind)
        2'd0: if (in_gap) begin
          if (done) begin
            chk(gap_len == exp_q[gi & 63], tag_q[gi & 63], gap_len, exp_q[gi & 63]);
            gi++; in_gap = 0;
          end else gap_len++;
        end
        2'd1: begin
          chk(bit_ready == 1'b0, "R7", int'(bit_ready), 0);
          if (in_gap) begin
            chk(gap_len == exp_q[gi & 63], tag_q[gi & 63], gap_len, exp_q[gi & 63]);
            gi++; in_gap = 0;
          end
          mon_frames++; idx = 0;
        end
        2'd2: begin
          chk(int'(ch_data) == (idx & 255), "R2", int'(ch_data), idx & 255);
          idx++;
        end
        default: begin
          chk(idx == r_len, (r_len == 1) ? "R11" : "R2", idx, r_len);
          chk(bit_ready == r_cov, "R7", int'(bit_ready), int'(r_cov));
          exp_q[ti & 63] = exp_gap(r_base, r_off, r_cov, bit_valid, bit_data);
          tag_q[ti & 63] = gap_tag(r_base, r_cov, bit_valid, bit_data);
          ti++; in_gap = 1; gap_len = 0;
        end
      endcase
    end
  end

  // bits: 0 none, 1 random valid, 2 always valid
  task automatic run_case(input int count, input int len, input int base, input int off,
                          input bit cov, input int bits, input int stop_after,
                          input bit poke, input string ctag);
    int cyc = 0;
    bit stop_sent = 0;
    int exp_frames;
    cfg_frame_count = 16'(count); cfg_frame_len = 16'(len);
    cfg_base_gap = 16'(base); cfg_gap_offset = 16'(off); cfg_covert = cov;
    r_count = count; r_len = (len == 0) ? 1 : len;
    r_base = base; r_off = off; r_cov = cov;
    mon_frames = 0; gi = 0; ti = 0; in_gap = 0; idx = 0;
    @(posedge clk); #1 run_start = 1'b1;
    @(posedge clk); #1 run_start = 1'b0;
    while (!done && cyc < 60000) begin
      @(posedge clk); #1;
      run_start = 1'b0; run_stop = 1'b0;
      cyc++;
      bit_valid = (bits == 2) ? 1'b1 : (bits == 1) ? 1'($urandom % 2) : 1'b0;
      bit_data  = 1'($urandom % 2);
      if (poke && cyc == 5) begin
        run_start = 1'b1;
        cfg_frame_count = 16'(count + 5); cfg_frame_len = 16'(len + 3);
        cfg_base_gap = 16'(base + 9); cfg_covert = ~cov;
      end
      if (stop_after >= 0 && !stop_sent && mon_frames == stop_after) begin
        run_stop = 1'b1; stop_sent = 1;
      end
    end
    bit_valid = 1'b0; run_start = 1'b0; run_stop = 1'b0;
    exp_frames = (stop_after >= 0) ? stop_after : count;
    chk(busy == 1'b0, "R8", int'(busy), 0);
    repeat (6) @(posedge clk);
    #1;
    chk(mon_frames == exp_frames, ctag, mon_frames, exp_frames);
    chk(gi == exp_frames, ctag, gi, exp_frames);
    chk(done == 1'b1 && ch_kind == 2'd0, "R8", int'(done), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(ch_kind == 2'd0, "R1", int'(ch_kind), 0);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(done == 1'b0, "R1", int'(done), 0);
    chk(bit_ready == 1'b0, "R1", int'(bit_ready), 0);
    mon_en = 1;

    run_case(3, 4, 20, 0, 0, 0, -1, 0, "R3");
    run_case(2, 2, 5, 0, 0, 1, -1, 0, "R4");
    run_case(6, 3, 30, 10, 1, 2, -1, 0, "R5");
    run_case(4, 3, 14, 9, 1, 2, -1, 0, "R6");
    run_case(3, 2, 25, 9, 1, 0, -1, 0, "R7");
    run_case(0, 4, 20, 0, 0, 0, -1, 0, "R8");
    run_case(2, 0, 13, 0, 0, 0, -1, 0, "R11");
    @(posedge clk); #1 run_stop = 1'b1;
    @(posedge clk); #1 run_stop = 1'b0;
    run_case(3, 2, 12, 0, 0, 0, -1, 0, "R9");
    run_case(40, 5, 16, 0, 0, 0, 3, 0, "R9");
    run_case(3, 4, 15, 0, 0, 0, -1, 1, "R10");
    run_case(2, 1518, 3562, 128, 1, 2, -1, 0, "R5");
    for (int k = 0; k < 8; k++) begin
      run_case(1 + int'($urandom % 5), int'($urandom % 7), int'($urandom % 41),
               int'($urandom % 31), 1'($urandom % 2), 1, -1, 0, "R8");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule